// File: doc/BRIEF.md
# Flash Option Word Protection Controller

This block sits between flash command requesters and the flash array controller and enforces the protection settings held in eight 16-bit option words. After every synchronous reset it reads the option words from an external option store, one word at a time. Each word holds a data byte in its low half and the bitwise inverse of that byte in its high half. From the loaded bytes the block derives a read-protection state and a 32-bit active-low write-protect mask. Both stay frozen until the next reset. Until loading finishes, or forever if a word fails its check, the block accepts no commands and reports full protection.

A debugger-attach input sets a sticky intrusion flag. When read protection and intrusion are both active, the block rejects data reads and instruction fetches. It rejects half-word programs and page erases that fall in a write-protected 16 kB region of the main array. It forces the high byte of every option-word program to the inverse of the low byte. When option word 0 is erased while read protection is active, the block first issues a main-array mass erase. Accepted commands are forwarded to the array controller. Every command ends with a one-cycle done pulse, which carries an error flag when the command was rejected.

Top module: `optprot_ctrl`

## Requirements
- R1: From reset until `load_done` rises (within 20 cycles of reset release), `cmd_ready` is low, `rdp_active` is high and `wp_mask` is all zeros. `cmd_ready` is never high while `load_done` is low.
- R2: A word is accepted when bits [15:8] equal the inverse of bits [7:0], or when the word is 0xFFFF (an erased word, taken as data 0xFF). Any other word sets `opt_fault`, which holds until reset. While `opt_fault` is set, `load_done` and `cmd_ready` stay low and full protection remains.
- R3: `rdp_active` is low after loading only when the data byte of word 0 is 0xA5. Any other value, including 0xFF, leaves it high.
- R4: `wp_mask` is {byte7, byte6, byte5, byte4}. Bit i covers the 16 kB region at 0x0800_0000 + i*0x4000, and a 0 bit protects that region.
- R5: Writing or erasing option words through commands leaves `rdp_active` and `wp_mask` unchanged until the next reset.
- R6: `intrusion` is set one cycle after `dbg_attached` is high. It stays set until a reset taken with `dbg_attached` low. A reset taken with `dbg_attached` high leaves it set.
- R7: `flash_gated` is high when `rdp_active` and `intrusion` are both high. In that state, opcode 0 (read) and opcode 1 (fetch) are rejected. Otherwise they are forwarded.
- R8: Opcode 2 (half-word program) and opcode 3 (page erase) are rejected when the address lies in 0x0800_0000..0x0807_FFFF and its region bit in `wp_mask` is 0. Addresses outside that range are not subject to the mask.
- R9: Opcode 4 (option program, word index = addr[3:1]) is forwarded with data {~d[7:0], d[7:0]}, whatever high byte was supplied.
- R10: Opcode 5 (option erase) to word 0 while `rdp_active` is high forwards opcode 6 (mass erase, address 0x0800_0000, data 0) and then opcode 5 on the next cycle. `cmd_ready` is low in between, and the done pulse comes with the second forward. Otherwise opcode 5 is forwarded directly.
- R11: An accepted command produces `rsp_done` on the next cycle, or on the second cycle in the R10 case. A rejected command pulses `rsp_done` and `rsp_err` together and forwards nothing. Opcodes 6 and 7 from requesters, and opcode 2 with addr[0]=1, are rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high full reset |
| dbg_attached | input | 1 | Debugger attach indication |
| opt_raddr | output | 3 | Option store word index |
| opt_rdata | input | 16 | Option store word, one cycle after address |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Command can be accepted |
| cmd_op | input | 3 | Command opcode |
| cmd_addr | input | 32 | Command byte address |
| cmd_data | input | 16 | Command data |
| fwd_valid | output | 1 | Forwarded command valid |
| fwd_op | output | 3 | Forwarded opcode |
| fwd_addr | output | 32 | Forwarded address |
| fwd_data | output | 16 | Forwarded data |
| rsp_done | output | 1 | Command completion pulse |
| rsp_err | output | 1 | Command rejected (with rsp_done) |
| load_done | output | 1 | Option words loaded and valid |
| opt_fault | output | 1 | Option word check failure |
| rdp_active | output | 1 | Read protection in force |
| intrusion | output | 1 | Latched debugger intrusion |
| flash_gated | output | 1 | Flash reads blocked |
| wp_mask | output | 32 | Active-low region write-protect mask |

## Verification
Some properties are checked on every cycle. These are: commands are refused before loading completes, the fault and intrusion flags are sticky, the protection state is frozen once loaded, option programs always carry a proper inverse byte, a rejection never comes with a forward, and a mass erase is always followed by the option erase. Other behaviours can only be shown by the bench's scenarios. These are: the decoding of particular option bytes into the read state and region mask, erased-versus-corrupt word handling, the deferral of option changes to the next reset, and intrusion surviving a reset taken with the debugger attached.

// File: rtl/optprot_pkg.sv
package optprot_pkg;
  typedef enum logic [2:0] {
    OP_READ     = 3'd0,
    OP_FETCH    = 3'd1,
    OP_PROG     = 3'd2,
    OP_PERASE   = 3'd3,
    OP_OPTPROG  = 3'd4,
    OP_OPTERASE = 3'd5,
    OP_MASS     = 3'd6,
    OP_RSVD     = 3'd7
  } op_e;

  localparam logic [7:0]  RDP_OPEN_CODE = 8'hA5;
  localparam logic [15:0] ERASED_WORD   = 16'hFFFF;
endpackage

// File: rtl/optprot_loader.sv
module optprot_loader #(
  parameter int NWORDS   = 8,
  parameter int NREG     = 32,
  parameter int WP_FIRST = 4,
  parameter int RDP_WORD = 0,
  localparam int IDXW    = $clog2(NWORDS),
  localparam int WPBYTES = NREG / 8
) (
  input  logic            clk,
  input  logic            rst,
  output logic [IDXW-1:0] opt_raddr,
  input  logic [15:0]     opt_rdata,
  output logic            load_done,
  output logic            opt_fault,
  output logic            rdp_active,
  output logic [NREG-1:0] wp_mask
);
  import optprot_pkg::*;

  logic [7:0]      optb [NWORDS];
  logic [IDXW-1:0] idx;
  logic            ph;
  logic            fin;
  logic            bad;
  logic            word_ok;
  logic [NREG-1:0] wp_next;

  assign opt_raddr = idx;
  assign word_ok   = (opt_rdata[15:8] == ~opt_rdata[7:0]) || (opt_rdata == ERASED_WORD);

  for (genvar b = 0; b < WPBYTES; b++) begin : g_wp
    assign wp_next[b*8 +: 8] = optb[WP_FIRST+b];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx        <= '0;
      ph         <= 1'b0;
      fin        <= 1'b0;
      bad        <= 1'b0;
      load_done  <= 1'b0;
      opt_fault  <= 1'b0;
      rdp_active <= 1'b1;
      wp_mask    <= '0;
      for (int i = 0; i < NWORDS; i++) optb[i] <= 8'hFF;
    end else if (fin) begin
      fin <= 1'b0;
      if (bad) begin
        opt_fault <= 1'b1;
      end else begin
        load_done  <= 1'b1;
        rdp_active <= (optb[RDP_WORD] != RDP_OPEN_CODE);
        wp_mask    <= wp_next;
      end
    end else if (!load_done && !opt_fault) begin
      ph <= ~ph;
      if (ph) begin
        optb[idx] <= opt_rdata[7:0];
        if (!word_ok) bad <= 1'b1;
        if (idx == IDXW'(NWORDS-1)) fin <= 1'b1;
        else                        idx <= idx + 1'b1;
      end
    end
  end

  p_fault_sticky_r2: assert property (@(posedge clk) disable iff (rst)
    opt_fault |=> opt_fault && !load_done);

  p_frozen_r5: assert property (@(posedge clk) disable iff (rst)
    (load_done && $past(load_done)) |-> ($stable(rdp_active) && $stable(wp_mask)));

  p_full_prot_r1: assert property (@(posedge clk) disable iff (rst)
    !load_done |-> (rdp_active && wp_mask == '0));
endmodule

// File: rtl/optprot_intrusion.sv
module optprot_intrusion (
  input  logic clk,
  input  logic rst,
  input  logic dbg_attached,
  output logic intrusion
);
  always_ff @(posedge clk) begin
    if (rst)               intrusion <= dbg_attached;
    else if (dbg_attached) intrusion <= 1'b1;
  end

  p_intr_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    intrusion |=> intrusion);

  p_intr_set_r6: assert property (@(posedge clk) disable iff (rst)
    dbg_attached |=> intrusion);
endmodule

// File: rtl/optprot_cmdgate.sv
module optprot_cmdgate #(
  parameter int              AW           = 32,
  parameter int              NREG         = 32,
  parameter int              REGION_SHIFT = 14,
  parameter int              IDXW         = 3,
  parameter logic [AW-1:0]   MAIN_BASE    = 32'h0800_0000,
  localparam int             RW           = $clog2(NREG),
  localparam logic [AW-1:0]  MAIN_SPAN    = AW'(NREG) << REGION_SHIFT
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  logic            rdp_active,
  input  logic            gated,
  input  logic [NREG-1:0] wp_mask,
  input  logic            cmd_valid,
  output logic            cmd_ready,
  input  logic [2:0]      cmd_op,
  input  logic [AW-1:0]   cmd_addr,
  input  logic [15:0]     cmd_data,
  output logic            fwd_valid,
  output logic [2:0]      fwd_op,
  output logic [AW-1:0]   fwd_addr,
  output logic [15:0]     fwd_data,
  output logic            rsp_done,
  output logic            rsp_err
);
  import optprot_pkg::*;

  op_e            op;
  logic [AW-1:0]  offset;
  logic           in_main;
  logic [RW-1:0]  region;
  logic           wr_locked;
  logic           rej;
  logic           mass_first;
  logic           pend;
  logic [AW-1:0]  held_addr;
  logic [15:0]    held_data;
  logic           accept;

  assign op        = op_e'(cmd_op);
  assign offset    = cmd_addr - MAIN_BASE;
  assign in_main   = offset < MAIN_SPAN;
  assign region    = offset[REGION_SHIFT +: RW];
  assign wr_locked = in_main && !wp_mask[region];
  assign cmd_ready = run && !pend;
  assign accept    = cmd_valid && cmd_ready;

  always_comb begin
    rej        = 1'b0;
    mass_first = 1'b0;
    case (op)
      OP_READ, OP_FETCH: rej = gated;
      OP_PROG:           rej = wr_locked || cmd_addr[0];
      OP_PERASE:         rej = wr_locked;
      OP_OPTPROG:        rej = 1'b0;
      OP_OPTERASE:       mass_first = rdp_active && (cmd_addr[IDXW:1] == '0);
      default:           rej = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend      <= 1'b0;
      held_addr <= '0;
      held_data <= '0;
      fwd_valid <= 1'b0;
      fwd_op    <= '0;
      fwd_addr  <= '0;
      fwd_data  <= '0;
      rsp_done  <= 1'b0;
      rsp_err   <= 1'b0;
    end else begin
      fwd_valid <= 1'b0;
      rsp_done  <= 1'b0;
      rsp_err   <= 1'b0;
      if (pend) begin
        pend      <= 1'b0;
        fwd_valid <= 1'b1;
        fwd_op    <= OP_OPTERASE;
        fwd_addr  <= held_addr;
        fwd_data  <= held_data;
        rsp_done  <= 1'b1;
      end else if (accept) begin
        if (rej) begin
          rsp_done <= 1'b1;
          rsp_err  <= 1'b1;
        end else if (mass_first) begin
          pend      <= 1'b1;
          held_addr <= cmd_addr;
          held_data <= cmd_data;
          fwd_valid <= 1'b1;
          fwd_op    <= OP_MASS;
          fwd_addr  <= MAIN_BASE;
          fwd_data  <= '0;
        end else begin
          fwd_valid <= 1'b1;
          fwd_op    <= cmd_op;
          fwd_addr  <= cmd_addr;
          fwd_data  <= (op == OP_OPTPROG) ? {~cmd_data[7:0], cmd_data[7:0]} : cmd_data;
          rsp_done  <= 1'b1;
        end
      end
    end
  end

  p_blocked_read_r7: assert property (@(posedge clk) disable iff (rst)
    (accept && (op == OP_READ || op == OP_FETCH) && gated) |=> (rsp_err && !fwd_valid));

  p_locked_write_r8: assert property (@(posedge clk) disable iff (rst)
    (accept && (op == OP_PROG || op == OP_PERASE) && wr_locked) |=> (rsp_err && !fwd_valid));

  p_opt_inverse_r9: assert property (@(posedge clk) disable iff (rst)
    (fwd_valid && fwd_op == OP_OPTPROG) |-> (fwd_data[15:8] == ~fwd_data[7:0]));

  p_mass_then_opt_r10: assert property (@(posedge clk) disable iff (rst)
    (fwd_valid && fwd_op == OP_MASS) |=> (fwd_valid && fwd_op == OP_OPTERASE && rsp_done));

  p_err_no_fwd_r11: assert property (@(posedge clk) disable iff (rst)
    rsp_err |-> (rsp_done && !fwd_valid));
endmodule

// File: rtl/optprot_ctrl.sv
module optprot_ctrl #(
  parameter int            AW           = 32,
  parameter int            NWORDS       = 8,
  parameter int            NREG         = 32,
  parameter int            REGION_SHIFT = 14,
  parameter int            WP_FIRST     = 4,
  parameter logic [AW-1:0] MAIN_BASE    = 32'h0800_0000,
  localparam int           IDXW         = $clog2(NWORDS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            dbg_attached,
  output logic [IDXW-1:0] opt_raddr,
  input  logic [15:0]     opt_rdata,
  input  logic            cmd_valid,
  output logic            cmd_ready,
  input  logic [2:0]      cmd_op,
  input  logic [AW-1:0]   cmd_addr,
  input  logic [15:0]     cmd_data,
  output logic            fwd_valid,
  output logic [2:0]      fwd_op,
  output logic [AW-1:0]   fwd_addr,
  output logic [15:0]     fwd_data,
  output logic            rsp_done,
  output logic            rsp_err,
  output logic            load_done,
  output logic            opt_fault,
  output logic            rdp_active,
  output logic            intrusion,
  output logic            flash_gated,
  output logic [NREG-1:0] wp_mask
);
  optprot_loader #(.NWORDS(NWORDS), .NREG(NREG), .WP_FIRST(WP_FIRST), .RDP_WORD(0)) u_loader (
    .clk(clk), .rst(rst), .opt_raddr(opt_raddr), .opt_rdata(opt_rdata),
    .load_done(load_done), .opt_fault(opt_fault), .rdp_active(rdp_active), .wp_mask(wp_mask)
  );

  optprot_intrusion u_intr (
    .clk(clk), .rst(rst), .dbg_attached(dbg_attached), .intrusion(intrusion)
  );

  assign flash_gated = rdp_active && intrusion;

  optprot_cmdgate #(.AW(AW), .NREG(NREG), .REGION_SHIFT(REGION_SHIFT), .IDXW(IDXW),
                    .MAIN_BASE(MAIN_BASE)) u_gate (
    .clk(clk), .rst(rst), .run(load_done), .rdp_active(rdp_active), .gated(flash_gated),
    .wp_mask(wp_mask), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .fwd_valid(fwd_valid), .fwd_op(fwd_op),
    .fwd_addr(fwd_addr), .fwd_data(fwd_data), .rsp_done(rsp_done), .rsp_err(rsp_err)
  );

  p_ready_needs_load_r1: assert property (@(posedge clk) disable iff (rst)
    cmd_ready |-> load_done);
endmodule

// File: tb/tb_optprot_ctrl.sv
module tb_optprot_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        dbg_attached = 1'b0;
  logic [2:0]  opt_raddr;
  logic [15:0] opt_rdata;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [2:0]  cmd_op = '0;
  logic [31:0] cmd_addr = '0;
  logic [15:0] cmd_data = '0;
  logic        fwd_valid;
  logic [2:0]  fwd_op;
  logic [31:0] fwd_addr;
  logic [15:0] fwd_data;
  logic        rsp_done, rsp_err, load_done, opt_fault, rdp_active, intrusion, flash_gated;
  logic [31:0] wp_mask;

  always #5 clk = ~clk;

  optprot_ctrl dut (
    .clk(clk), .rst(rst), .dbg_attached(dbg_attached), .opt_raddr(opt_raddr), .opt_rdata(opt_rdata),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
    .cmd_data(cmd_data), .fwd_valid(fwd_valid), .fwd_op(fwd_op), .fwd_addr(fwd_addr),
    .fwd_data(fwd_data), .rsp_done(rsp_done), .rsp_err(rsp_err), .load_done(load_done),
    .opt_fault(opt_fault), .rdp_active(rdp_active), .intrusion(intrusion),
    .flash_gated(flash_gated), .wp_mask(wp_mask)
  );

  // option store model: registered read, updated by forwarded option commands
  logic [15:0] store [8];
  logic        poke_en = 1'b0;
  logic [2:0]  poke_idx = '0;
  logic [15:0] poke_val = '0;

  always @(posedge clk) begin
    opt_rdata <= store[opt_raddr];
    if (poke_en) store[poke_idx] <= poke_val;
    else if (fwd_valid && fwd_op == 3'd4) store[fwd_addr[3:1]] <= fwd_data;
    else if (fwd_valid && fwd_op == 3'd5) store[fwd_addr[3:1]] <= 16'hFFFF;
  end

  typedef struct {
    logic [2:0]  op;
    logic [31:0] addr;
    logic [15:0] data;
    string       tag;
  } fwd_t;
  typedef struct {
    logic  err;
    string tag;
  } rsp_t;
  fwd_t fq[$];
  rsp_t rq[$];

  int n_cmp = 0;
  int n_bad = 0;
  logic        m_rdp, m_intr;
  logic [31:0] m_wp;

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (fwd_valid) begin
        if (fq.size() == 0) chk("R11", "unexpected forward op", {29'd0, fwd_op}, 32'hFFFF_FFFF);
        else begin
          fwd_t e;
          e = fq.pop_front();
          chk(e.tag, "fwd op", {29'd0, fwd_op}, {29'd0, e.op});
          chk(e.tag, "fwd addr", fwd_addr, e.addr);
          chk(e.tag, "fwd data", {16'd0, fwd_data}, {16'd0, e.data});
        end
      end
      if (rsp_done) begin
        if (rq.size() == 0) chk("R11", "unexpected done", 32'd1, 32'd0);
        else begin
          rsp_t r;
          r = rq.pop_front();
          chk(r.tag, "rsp err", {31'd0, rsp_err}, {31'd0, r.err});
        end
      end else if (rsp_err) chk("R11", "err without done", 32'd1, 32'd0);
    end
  end

  task automatic poke(input int idx, input logic [15:0] val);
    @(negedge clk);
    poke_en = 1'b1; poke_idx = 3'(idx); poke_val = val;
    @(negedge clk);
    poke_en = 1'b0;
  endtask

  task automatic do_reset(input logic dbg, input logic expect_fault);
    @(negedge clk);
    dbg_attached = dbg;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    m_rdp  = !(store[0] == 16'h5AA5);
    m_wp   = {store[7][7:0], store[6][7:0], store[5][7:0], store[4][7:0]};
    m_intr = dbg;
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "load_done during load", {31'd0, load_done}, 32'd0);
    chk("R1", "cmd_ready during load", {31'd0, cmd_ready}, 32'd0);
    chk("R1", "rdp during load", {31'd0, rdp_active}, 32'd1);
    chk("R1", "wp during load", wp_mask, 32'd0);
    for (int i = 0; i < 17 && !load_done; i++) @(negedge clk);
    if (expect_fault) begin
      repeat (5) @(negedge clk);
      chk("R2", "fault set", {31'd0, opt_fault}, 32'd1);
      chk("R2", "load_done low", {31'd0, load_done}, 32'd0);
      chk("R2", "ready low", {31'd0, cmd_ready}, 32'd0);
      chk("R2", "rdp held", {31'd0, rdp_active}, 32'd1);
      chk("R2", "wp held", wp_mask, 32'd0);
    end else begin
      chk("R1", "load_done by 20 cycles", {31'd0, load_done}, 32'd1);
      chk("R2", "no fault", {31'd0, opt_fault}, 32'd0);
      chk("R3", "rdp state", {31'd0, rdp_active}, {31'd0, m_rdp});
      chk("R4", "wp mask", wp_mask, m_wp);
      chk("R6", "intrusion after reset", {31'd0, intrusion}, {31'd0, m_intr});
      chk("R7", "flash_gated", {31'd0, flash_gated}, {31'd0, m_rdp & m_intr});
    end
  endtask

  task automatic send(input logic [2:0] op, input logic [31:0] addr, input logic [15:0] data, input string tag);
    logic gated, inmain, locked, rej;
    int   reg_i;
    fwd_t f;
    rsp_t r;
    gated  = m_rdp && m_intr;
    inmain = (addr >= 32'h0800_0000) && (addr < 32'h0808_0000);
    reg_i  = int'((addr - 32'h0800_0000) >> 14);
    locked = inmain && !m_wp[reg_i[4:0]];
    case (op)
      3'd0, 3'd1: rej = gated;
      3'd2:       rej = locked || addr[0];
      3'd3:       rej = locked;
      3'd4, 3'd5: rej = 1'b0;
      default:    rej = 1'b1;
    endcase
    if (!rej && op == 3'd5 && addr[3:1] == 3'd0 && m_rdp) begin
      f.op = 3'd6; f.addr = 32'h0800_0000; f.data = 16'h0000; f.tag = tag;
      fq.push_back(f);
    end
    if (!rej) begin
      f.op = op; f.addr = addr; f.tag = tag;
      f.data = (op == 3'd4) ? {~data[7:0], data[7:0]} : data;
      fq.push_back(f);
    end
    r.err = rej; r.tag = tag;
    rq.push_back(r);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = addr; cmd_data = data;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic drain();
    repeat (4) @(negedge clk);
    chk("R11", "forward queue empty", fq.size(), 0);
    chk("R11", "response queue empty", rq.size(), 0);
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    // scenario 1: read protection open, two regions locked
    poke(0, 16'h5AA5);
    for (int i = 1; i < 8; i++) poke(i, 16'hFFFF);
    poke(4, 16'h01FE);
    poke(6, 16'h807F);
    do_reset(1'b0, 1'b0);
    chk("R4", "wp decode value", wp_mask, 32'hFF7F_FFFE);
    send(3'd0, 32'h0800_0100, 16'h0000, "R7");
    send(3'd2, 32'h0800_0010, 16'h1111, "R8");
    send(3'd2, 32'h0800_4000, 16'h2222, "R8");
    send(3'd3, 32'h0805_C800, 16'h0000, "R8");
    send(3'd3, 32'h0806_0000, 16'h0000, "R8");
    send(3'd2, 32'h0808_0800, 16'h3333, "R8");
    send(3'd2, 32'h0800_4001, 16'h4444, "R11");
    send(3'd7, 32'h0800_4000, 16'h0000, "R11");
    send(3'd6, 32'h0800_4000, 16'h0000, "R11");
    send(3'd4, 32'h0808_0804, 16'hFF34, "R9");
    send(3'd5, 32'h0808_0800, 16'h0000, "R10");
    drain();
    chk("R5", "rdp unchanged after option erase", {31'd0, rdp_active}, 32'd0);
    chk("R5", "wp unchanged", wp_mask, 32'hFF7F_FFFE);
    @(negedge clk); dbg_attached = 1'b1; m_intr = 1'b1;
    @(negedge clk); dbg_attached = 1'b0;
    chk("R6", "intrusion latched", {31'd0, intrusion}, 32'd1);
    @(negedge clk);
    chk("R6", "intrusion sticky", {31'd0, intrusion}, 32'd1);
    chk("R7", "not gated while rdp open", {31'd0, flash_gated}, 32'd0);
    send(3'd1, 32'h0800_0200, 16'h0000, "R7");
    drain();
    // scenario 2: word 0 erased, reset taken with debugger attached
    do_reset(1'b1, 1'b0);
    chk("R6", "intrusion kept over attached reset", {31'd0, intrusion}, 32'd1);
    chk("R3", "erased byte enables rdp", {31'd0, rdp_active}, 32'd1);
    chk("R7", "gated", {31'd0, flash_gated}, 32'd1);
    send(3'd0, 32'h0800_0100, 16'h0000, "R7");
    send(3'd1, 32'h0800_0100, 16'h0000, "R7");
    send(3'd5, 32'h0808_0800, 16'h0000, "R10");
    send(3'd4, 32'h0808_0800, 16'h00A5, "R9");
    send(3'd2, 32'h0800_0000, 16'h5555, "R8");
    drain();
    chk("R5", "rdp still active before reset", {31'd0, rdp_active}, 32'd1);
    // scenario 3: detached reset clears intrusion, rdp reopened
    do_reset(1'b0, 1'b0);
    chk("R6", "intrusion cleared", {31'd0, intrusion}, 32'd0);
    chk("R3", "A5 opens read", {31'd0, rdp_active}, 32'd0);
    send(3'd1, 32'h0800_0100, 16'h0000, "R7");
    drain();
    // scenario 4: corrupt word
    poke(3, 16'h1234);
    do_reset(1'b0, 1'b1);
    drain();
    report();
  end
endmodule